// File: doc/BRIEF.md
# Extended CAN Identifier Acceptance Filter

This block decides which message centers accept a received 29-bit extended CAN identifier. Each of the fourteen message centers supplies a stored 29-bit arbitration identifier and two control bits: an extended-format select and a masking enable. One global mask is shared by all centers. Where a mask bit is 1, the received bit must equal the center's arbitration bit. Where a mask bit is 0, that bit position is a don't-care. The mask affects a center only when both of that center's control bits are set. Every other center uses an exact compare over all 29 bits.

The mask is held in four byte-wide registers on a 16-bit word-addressed register bus, with a separate write strobe for each byte. Software may change the mask only while the software-initialization flag is high. A filtering request is a single-cycle strobe with the identifier. One clock later the block returns a result pulse, the vector of matching centers, and the number of the lowest-numbered matching center, or 0 when no center matched.

Top module: `can_ext_filter`

## Requirements
- R1: After reset every mask bit is 0, both mask words read back 0x0000, and `res_valid` is low.
- R2: For a center with `ctr_ext`=1 and `ctr_mask_en`=1, the center matches exactly when the received identifier equals its arbitration identifier at every bit position where the mask bit is 1. Mask bits that are 0 are ignored.
- R3: For a center with `ctr_ext`=0 or `ctr_mask_en`=0, the global mask has no effect. The center matches only when all 29 bits are equal.
- R4: A mask register write takes effect only while `sw_init`=1. A write made while `sw_init`=0 leaves the readback and the filtering unchanged.
- R5: Word 0x04 holds mask bits 28..21 in data bits 7:0 and mask bits 20..13 in data bits 15:8. Word 0x05 holds mask bits 12..5 in data bits 7:0 and mask bits 4..0 in data bits 15:11. The higher mask bit is always in the higher data bit.
- R6: Data bits 10:8 of word 0x05 always read 0, and writes to them are discarded.
- R7: `reg_be[0]` enables the write of data bits 7:0 and `reg_be[1]` enables the write of data bits 15:8. A byte whose strobe is low keeps its value.
- R8: Bit c of `res_hit` reports center c+1. `res_idx` is the number (1..14) of the lowest-numbered matching center, or 0 when no center matches.
- R9: A request with `rx_valid` high produces `res_valid` high for exactly one cycle on the next clock. In a cycle with no request, `res_valid` is low on the next clock.
- R10: When the mask is all zero, every center with both control bits set accepts any identifier.
- R11: A word address other than 0x04 or 0x05 reads 0x0000, and a write to it changes no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_init | input | 1 | Software-initialization flag; permits mask writes |
| reg_wr | input | 1 | Register bus write strobe |
| reg_addr | input | 8 | Register bus word address |
| reg_wdata | input | 16 | Register bus write data |
| reg_be | input | 2 | Byte write enables (bit 1 high byte, bit 0 low byte) |
| reg_rdata | output | 16 | Register bus read data for `reg_addr` (combinational) |
| ctr_arb | input | 406 | Arbitration identifiers, center c+1 at bits 29c+28..29c |
| ctr_ext | input | 14 | Extended-format select per center |
| ctr_mask_en | input | 14 | Mask enable per center |
| rx_valid | input | 1 | Filtering request strobe |
| rx_id | input | 29 | Received extended identifier |
| res_valid | output | 1 | Result pulse, one clock after the request |
| res_hit | output | 14 | Matching-center vector |
| res_idx | output | 4 | Lowest-numbered matching center, 0 for none |

## Verification
The hardest case to reach from the ports is a match that depends on one particular mask bit that lives in a particular byte lane. Such a case exposes a swapped byte, a shifted field, or a tail byte misplaced over the dead bits. To reach it, the stimulus walks a single set mask bit through all 29 positions, each time writing ones into the dead bits. For each position it sends two identifiers: one that differs from the center only in the masked bit and one that differs only in the neighbouring unmasked bit. Further stimulus covers overlapping matches among several centers, using partial masks over small consecutive identifiers. It also covers every combination of the two control bits against a mask that hides low-order differences.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int EXT_ID_W = 29;
    localparam int REG_W    = 16;

    typedef logic [EXT_ID_W-1:0] ext_id_t;

    // Mask storage: packed so that the 29-bit view is bit 28 down to bit 0.
    typedef struct packed {
        logic [7:0] top;    // bits 28..21
        logic [7:0] upper;  // bits 20..13
        logic [7:0] lower;  // bits 12..5
        logic [4:0] tail;   // bits 4..0
    } gmask_t;

    typedef struct packed {
        logic    ext;
        logic    msk_en;
        ext_id_t arb;
    } ctr_cfg_t;
endpackage

// File: rtl/can_gmask_regs.sv
module can_gmask_regs
    import can_filt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int MASK_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_init,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [1:0]        be,
    output logic [REG_W-1:0]  rdata,
    output ext_id_t           mask
);
    localparam logic [ADDR_W-1:0] LO_WORD = ADDR_W'(MASK_BASE);
    localparam logic [ADDR_W-1:0] HI_WORD = ADDR_W'(MASK_BASE + 1);

    gmask_t mask_d, mask_q;
    logic   unused_dead_w;

    assign unused_dead_w = ^wdata[10:8];

    always_comb begin
        mask_d = mask_q;
        if (wr && sw_init) begin
            if (addr == LO_WORD) begin
                if (be[0]) mask_d.top   = wdata[7:0];
                if (be[1]) mask_d.upper = wdata[15:8];
            end else if (addr == HI_WORD) begin
                if (be[0]) mask_d.lower = wdata[7:0];
                if (be[1]) mask_d.tail  = wdata[15:11];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    always_comb begin
        if (addr == LO_WORD)      rdata = {mask_q.upper, mask_q.top};
        else if (addr == HI_WORD) rdata = {mask_q.tail, 3'b000, mask_q.lower};
        else                      rdata = '0;
    end

    assign mask = ext_id_t'(mask_q);
endmodule

// File: rtl/can_ctr_cmp.sv
module can_ctr_cmp
    import can_filt_pkg::*;
(
    input  ext_id_t  rx_id,
    input  ctr_cfg_t cfg,
    input  ext_id_t  gmask,
    output logic     hit
);
    ext_id_t care_w;
    ext_id_t diff_w;

    always_comb begin
        care_w = (cfg.ext && cfg.msk_en) ? gmask : '1;
        diff_w = (rx_id ^ cfg.arb) & care_w;
        hit    = (diff_w == '0);
    end
endmodule

// File: rtl/can_hit_prio.sv
module can_hit_prio #(
    parameter int N     = 14,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     hits,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i + 1);
        end
    end
endmodule

// File: rtl/can_ext_filter.sv
module can_ext_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_CTR   = 14,
    parameter int ADDR_W    = 8,
    parameter int MASK_BASE = 4,
    localparam int IDX_W    = $clog2(NUM_CTR + 1),
    localparam int ARB_W    = NUM_CTR * EXT_ID_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_init,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic [1:0]          reg_be,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [ARB_W-1:0]    ctr_arb,
    input  logic [NUM_CTR-1:0]  ctr_ext,
    input  logic [NUM_CTR-1:0]  ctr_mask_en,
    input  logic                rx_valid,
    input  logic [EXT_ID_W-1:0] rx_id,
    output logic                res_valid,
    output logic [NUM_CTR-1:0]  res_hit,
    output logic [IDX_W-1:0]    res_idx
);
    typedef struct packed {
        logic               valid;
        logic [NUM_CTR-1:0] hit;
        logic [IDX_W-1:0]   idx;
    } res_t;

    ext_id_t            mask_w;
    ctr_cfg_t           cfg_w [NUM_CTR];
    logic [NUM_CTR-1:0] hits_w;
    logic [IDX_W-1:0]   win_w;
    res_t               res_d, res_q;

    can_gmask_regs #(
        .ADDR_W    (ADDR_W),
        .MASK_BASE (MASK_BASE)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_init (sw_init),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .be      (reg_be),
        .rdata   (reg_rdata),
        .mask    (mask_w)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        assign cfg_w[g].ext    = ctr_ext[g];
        assign cfg_w[g].msk_en = ctr_mask_en[g];
        assign cfg_w[g].arb    = ctr_arb[g*EXT_ID_W +: EXT_ID_W];

        can_ctr_cmp i_cmp (
            .rx_id (rx_id),
            .cfg   (cfg_w[g]),
            .gmask (mask_w),
            .hit   (hits_w[g])
        );
    end

    can_hit_prio #(
        .N     (NUM_CTR),
        .IDX_W (IDX_W)
    ) i_prio (
        .hits (hits_w),
        .idx  (win_w)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = rx_valid;
        if (rx_valid) begin
            res_d.hit = hits_w;
            res_d.idx = win_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_idx   = res_q.idx;
endmodule

// File: rtl/can_ext_filter_chk.sv
module can_ext_filter_chk #(
    parameter int NUM_CTR   = 14,
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 8,
    parameter int MASK_BASE = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sw_init,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [15:0]        reg_rdata,
    input logic               rx_valid,
    input logic               res_valid,
    input logic [NUM_CTR-1:0] res_hit,
    input logic [IDX_W-1:0]   res_idx,
    input logic [28:0]        mask_w
);
    localparam int HW = 1 << IDX_W;
    localparam logic [ADDR_W-1:0] LO_WORD = ADDR_W'(MASK_BASE);
    localparam logic [ADDR_W-1:0] HI_WORD = ADDR_W'(MASK_BASE + 1);

    logic [HW-1:0] hit_ext;
    logic [HW-1:0] below;
    logic [HW-1:0] one_w;

    assign one_w   = HW'(1);
    assign hit_ext = HW'({res_hit, 1'b0});
    assign below   = hit_ext & ((one_w << res_idx) - one_w);

    assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> res_valid);
    assert_result_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !res_valid);
    assert_none_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit == '0) |-> res_idx == '0);
    assert_some_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit != '0) |-> res_idx != '0);
    assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_idx != '0) |-> (hit_ext[res_idx] && below == '0));
    assert_mask_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_init |=> $stable(mask_w));
    assert_dead_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == HI_WORD) |-> reg_rdata[10:8] == 3'b000);
    assert_other_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != LO_WORD && reg_addr != HI_WORD) |-> reg_rdata == 16'h0000);
endmodule

bind can_ext_filter can_ext_filter_chk #(
    .NUM_CTR   (NUM_CTR),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W),
    .MASK_BASE (MASK_BASE)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_init   (sw_init),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .rx_valid  (rx_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_idx   (res_idx),
    .mask_w    (mask_w)
);

// File: tb/test_can_ext_filter.sv
`timescale 1ns/1ps
module test_can_ext_filter;
    localparam int N  = 14;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_init = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [1:0]    reg_be = '0;
    logic [15:0]   reg_rdata;
    logic [N*29-1:0] ctr_arb = '0;
    logic [N-1:0]  ctr_ext = '0;
    logic [N-1:0]  ctr_mask_en = '0;
    logic          rx_valid = 1'b0;
    logic [28:0]   rx_id = '0;
    logic          res_valid;
    logic [N-1:0]  res_hit;
    logic [IW-1:0] res_idx;

    int n_run = 0;
    int n_fail = 0;
    logic [28:0] m_arb [N];
    logic        m_ext [N];
    logic        m_men [N];
    logic [28:0] m_mask = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    can_ext_filter i_can_ext_filter (
        .clk(clk), .rst_n(rst_n), .sw_init(sw_init), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
        .reg_rdata(reg_rdata), .ctr_arb(ctr_arb), .ctr_ext(ctr_ext),
        .ctr_mask_en(ctr_mask_en), .rx_valid(rx_valid), .rx_id(rx_id),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        logic [31:0] x = seed;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        seed = x;
        return x;
    endfunction

    task automatic push_cfg();
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
            ctr_arb[c*29 +: 29] = m_arb[c];
            ctr_ext[c]          = m_ext[c];
            ctr_mask_en[c]      = m_men[c];
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // R5 layout; dead bits of word 0x05 are written as ones (R6)
    task automatic set_mask(input logic [28:0] m);
        bus_write(8'h04, {m[20:13], m[28:21]}, 2'b11);
        bus_write(8'h05, {m[4:0], 3'b111, m[12:5]}, 2'b11);
        if (sw_init) m_mask = m;
    endtask

    task automatic filt(input string req, input logic [28:0] id);
        logic [N-1:0]  exp_hit;
        logic [IW-1:0] exp_idx;
        logic [28:0]   care;
        @(negedge clk);
        chk("R9 idle", {31'd0, res_valid}, 32'd0);
        rx_valid = 1'b1; rx_id = id;
        @(negedge clk);
        rx_valid = 1'b0;
        exp_hit = '0;
        exp_idx = '0;
        for (int c = N - 1; c >= 0; c--) begin
            care = (m_ext[c] && m_men[c]) ? m_mask : '1;
            exp_hit[c] = (((id ^ m_arb[c]) & care) == '0);
            if (exp_hit[c]) exp_idx = IW'(c + 1);
        end
        chk("R9 valid", {31'd0, res_valid}, 32'd1);
        chk({req, " hit"}, 32'(res_hit), 32'(exp_hit));
        chk({req, " idx"}, 32'(res_idx), 32'(exp_idx));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all R): actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [28:0] m, a;
        for (int c = 0; c < N; c++) begin
            m_arb[c] = 29'(c + 1); m_ext[c] = 1'b1; m_men[c] = 1'b1;
        end
        push_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h04, rd); chk("R1 word04", 32'(rd), 32'h0);
        bus_read(8'h05, rd); chk("R1 word05", 32'(rd), 32'h0);
        chk("R1 res_valid", {31'd0, res_valid}, 32'd0);

        // R4: writes blocked without sw_init
        bus_write(8'h04, 16'hFFFF, 2'b11);
        bus_write(8'h05, 16'hFFFF, 2'b11);
        bus_read(8'h04, rd); chk("R4 locked word04", 32'(rd), 32'h0);
        bus_read(8'h05, rd); chk("R4 locked word05", 32'(rd), 32'h0);

        // R10: all-zero mask accepts everything
        for (int k = 0; k < 8; k++) filt("R10", 29'(rnd()));

        sw_init = 1'b1;
        // R6 / R5 readback with all ones
        bus_write(8'h04, 16'hFFFF, 2'b11);
        bus_write(8'h05, 16'hFFFF, 2'b11);
        bus_read(8'h04, rd); chk("R5 word04 ones", 32'(rd), 32'hFFFF);
        bus_read(8'h05, rd); chk("R6 word05 dead bits", 32'(rd), 32'hF8FF);

        // R7 byte strobes
        bus_write(8'h04, 16'h1234, 2'b01);
        bus_read(8'h04, rd); chk("R7 low strobe", 32'(rd), 32'hFF34);
        bus_write(8'h04, 16'h5600, 2'b10);
        bus_read(8'h04, rd); chk("R7 high strobe", 32'(rd), 32'h5634);
        bus_write(8'h05, 16'h00AB, 2'b01);
        bus_read(8'h05, rd); chk("R7 word05 low strobe", 32'(rd), 32'hF8AB);
        bus_write(8'h05, 16'h0000, 2'b00);
        bus_read(8'h05, rd); chk("R7 no strobe", 32'(rd), 32'hF8AB);

        // R11 other addresses
        bus_write(8'h06, 16'hFFFF, 2'b11);
        bus_write(8'h03, 16'h0000, 2'b11);
        bus_read(8'h06, rd); chk("R11 read other", 32'(rd), 32'h0);
        bus_read(8'h04, rd); chk("R11 word04 kept", 32'(rd), 32'h5634);
        bus_read(8'h05, rd); chk("R11 word05 kept", 32'(rd), 32'hF8AB);

        // R5 walking single mask bit
        m_arb[0] = '0;
        push_cfg();
        for (int b = 0; b < 29; b++) begin
            m = 29'(1) << b;
            set_mask(m);
            bus_read(8'h04, rd); chk("R5 walk word04", 32'(rd), 32'({m[20:13], m[28:21]}));
            bus_read(8'h05, rd); chk("R5 walk word05", 32'(rd), 32'({m[4:0], 3'b000, m[12:5]}));
            filt("R5 masked bit", m);
            filt("R5 free bit", 29'(1) << ((b + 1) % 29));
        end

        // R3 control-bit combinations
        a = 29'h0ABC_DE12;
        set_mask(29'h1FFF_FF00);
        for (int c = 0; c < N; c++) begin
            m_arb[c] = a ^ 29'(c << 12); m_ext[c] = c[0]; m_men[c] = c[1];
        end
        m_arb[0] = a; m_arb[1] = a; m_arb[2] = a; m_arb[3] = a;
        push_cfg();
        filt("R3 exact id", a);
        filt("R3 low diff", a ^ 29'h05);
        filt("R3 high diff", a ^ 29'h100);
        for (int k = 0; k < 16; k++) filt("R3 sweep", a ^ 29'(rnd() & 32'hFF));

        // R8 priority with overlapping matches
        for (int c = 0; c < N; c++) begin
            m_arb[c] = 29'(c + 1); m_ext[c] = 1'b1; m_men[c] = 1'b1;
        end
        push_cfg();
        for (int k = 0; k < 5; k++) begin
            set_mask(~((29'(1) << k) - 29'(1)));
            for (int id = 0; id < 17; id++) filt("R8", 29'(id));
        end
        set_mask('0);
        filt("R10 zero mask", 29'h1FFF_FFFF);

        // R2 random masks and configurations
        for (int t = 0; t < 40; t++) begin
            set_mask(29'(rnd()));
            for (int c = 0; c < N; c++) begin
                m_arb[c] = 29'(rnd()); m_ext[c] = rnd() < 32'hC000_0000;
                m_men[c] = rnd() < 32'hC000_0000;
            end
            push_cfg();
            for (int k = 0; k < 6; k++) begin
                a = m_arb[rnd() % N];
                filt("R2", a ^ (29'(rnd()) & ~m_mask & 29'(rnd())));
            end
        end

        // R4: lock again, mask keeps old value
        set_mask(29'h1FFF_FFFF);
        sw_init = 1'b0;
        set_mask('0);
        bus_read(8'h04, rd); chk("R4 locked word04 kept", 32'(rd), 32'hFFFF);
        bus_read(8'h05, rd); chk("R4 locked word05 kept", 32'(rd), 32'hF8FF);
        for (int k = 0; k < 8; k++) filt("R4 filter uses old mask", m_arb[k] ^ 29'(k));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule